// File: doc/BRIEF.md
# Single-Wire Echoing Memory-Read Monitor

This block is the serial front end of a debug monitor. The link is one open-drain data line that carries both directions. The line idles high. The host sends bytes as NRZ frames: a low start bit, eight data bits with the least significant bit first, and a high stop bit. The bit period is a whole number of clock cycles, given on the `baud_div` input. Both directions use the same period. The block samples each received bit at its midpoint. It sends every good byte back on the same line at once, so the host can check what arrived. It pulls the line low only through its drive-enable output.

On top of the echo, a small decoder accepts one command, a memory read. The command is an opcode byte followed by the high and then the low address byte. When the echo of the low address byte has ended, the block reads a synchronous memory port and sends the returned byte on the line.

A host can also send a break: a start bit followed by nine more low bit periods. The block answers a break by leaving the line high for two bit periods and then sending an all-zero byte. A break also clears any partly received command.

Top module: `mon_link`

## Requirements
- R1: Every frame the block sends holds the line low for one start bit, then sends the eight data bits least significant first, then a high stop bit. Each bit lasts exactly `baud_div` clock cycles, and `line_pull_low` = 1 means a low bit. The receiver uses the same period, and changing `baud_div` between transfers changes both directions.
- R2: A byte received with a high stop bit is echoed unchanged. The echo's start bit is driven from the second clock cycle after the receiver samples the middle of the stop bit.
- R3: The receiver starts a frame on a high-to-low change of the line. It checks the line `baud_div/2` cycles later (integer division), and samples each later bit one bit period apart. If the line is back high at that first check, the event is dropped and nothing is sent.
- R4: The read opcode is 0x4A. After the opcode, a high address byte and a low address byte, `mem_rd` pulses for one cycle with `mem_addr` = {high, low}. The pulse comes in the first cycle after the low byte's echo ends.
- R5: The byte on `mem_data` in the cycle after the `mem_rd` pulse is sent as a frame. Its start bit begins two cycles after the end of the final echo.
- R6: A byte other than 0x4A received while no command is in progress is echoed and causes no memory read.
- R7: A start bit plus nine low bit periods is a break. The stop sample is low and all data bits are zero. The block then leaves the line released for two bit periods and sends the byte 0x00.
- R8: A break makes the decoder wait for a fresh opcode. Address bytes that follow the break are echoed only.
- R9: While the block is sending, including the pause after a break, the receiver ignores the line. A low pulse from the host in that time is neither decoded nor echoed.
- R10: After reset, the line is released, `mem_rd` is low, and the receiver waits for a start bit.
- R11: A frame whose stop sample is low but whose data is not all zero is discarded, with no echo.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_in | input | 1 | Level on the shared data line |
| baud_div | input | DIV_W | Bit period in clock cycles (at least 2) |
| line_pull_low | output | 1 | Drive enable: 1 pulls the line low |
| mem_rd | output | 1 | One-cycle memory read strobe |
| mem_addr | output | 16 | Memory read address |
| mem_data | input | 8 | Memory read data, valid the cycle after `mem_rd` |

## Verification
The memory read strobe fires in the same cycle the transmitter reports the end of the last address echo. The result transfer then has to start two cycles later without a gap or an overlap. A second overlap comes from the host pulling the shared line low while the echo is still on the wire. The bench provokes both: a full read command, and a host pulse placed in the middle of an echo. It then compares the drive enable and the memory strobe with a behavioural model on every clock. Any stray echo, a late strobe or a shifted result frame shows up as a mismatch in a specific cycle.

// File: rtl/mon_link_pkg.sv
package mon_link_pkg;

    localparam int BYTE_W     = 8;
    localparam int FRAME_BITS = BYTE_W + 2;
    localparam int ADDR_W     = 2 * BYTE_W;

    typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_e;
    typedef enum logic [1:0] {TX_IDLE, TX_PAUSE, TX_SEND} tx_state_e;
    typedef enum logic [2:0] {
        CM_WAIT, CM_HI, CM_LO, CM_ECHO, CM_MEM, CM_RESULT
    } cmd_state_e;

    // one-cycle receive event
    typedef struct packed {
        logic              valid;
        logic              brk;
        logic [BYTE_W-1:0] data;
    } rx_evt_t;

    // transmit request, sampled only when the transmitter is idle
    typedef struct packed {
        logic              start;
        logic              pause;
        logic [BYTE_W-1:0] data;
    } tx_req_t;

    // stop bit high, data LSB first after a low start bit
    function automatic logic [FRAME_BITS-1:0] make_frame(input logic [BYTE_W-1:0] d);
        return {1'b1, d, 1'b0};
    endfunction

endpackage

// File: rtl/mon_link_rx.sv
module mon_link_rx
    import mon_link_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             line_in,
    input  logic             tx_busy,
    input  logic [DIV_W-1:0] div,
    output rx_evt_t          evt
);

    rx_state_e         st;
    logic [DIV_W-1:0]  cnt;
    logic [2:0]        bitn;
    logic [BYTE_W-1:0] sh;
    logic              prev;
    logic [DIV_W-1:0]  half;

    assign half = div >> 1;

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= RX_IDLE;
            cnt  <= '0;
            bitn <= '0;
            sh   <= '0;
            prev <= 1'b1;
            evt  <= '0;
        end else begin
            prev <= line_in;
            evt  <= '0;
            unique case (st)
                RX_IDLE: begin
                    if (!tx_busy && prev && !line_in) begin
                        st  <= RX_START;
                        cnt <= '0;
                    end
                end
                RX_START: begin
                    if (cnt == half - 1'b1) begin
                        cnt  <= '0;
                        bitn <= '0;
                        st   <= line_in ? RX_IDLE : RX_DATA;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                RX_DATA: begin
                    if (cnt == div - 1'b1) begin
                        cnt  <= '0;
                        sh   <= {line_in, sh[BYTE_W-1:1]};
                        bitn <= bitn + 1'b1;
                        if (bitn == 3'd7) st <= RX_STOP;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                RX_STOP: begin
                    if (cnt == div - 1'b1) begin
                        cnt <= '0;
                        st  <= RX_IDLE;
                        if (line_in) begin
                            evt.valid <= 1'b1;
                            evt.data  <= sh;
                        end else if (sh == '0) begin
                            evt.brk <= 1'b1;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: st <= RX_IDLE;
            endcase
        end
    end

    // R9
    rx_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (st == RX_IDLE && tx_busy) |=> (st == RX_IDLE));

    // R1
    stop_high_chk: assert property (@(posedge clk) disable iff (rst)
        evt.valid |-> $past(line_in));

    // R7
    brk_low_chk: assert property (@(posedge clk) disable iff (rst)
        evt.brk |-> !$past(line_in));

endmodule

// File: rtl/mon_link_tx.sv
module mon_link_tx
    import mon_link_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div,
    input  tx_req_t          req,
    output logic             busy,
    output logic             done,
    output logic             drv_lo
);

    tx_state_e             st;
    logic [DIV_W:0]        cnt;
    logic [3:0]            bitn;
    logic [FRAME_BITS-1:0] sh;

    assign busy   = (st != TX_IDLE);
    assign drv_lo = (st == TX_SEND) && !sh[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= TX_IDLE;
            cnt  <= '0;
            bitn <= '0;
            sh   <= '1;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (st)
                TX_IDLE: begin
                    if (req.start) begin
                        sh   <= make_frame(req.data);
                        cnt  <= '0;
                        bitn <= '0;
                        st   <= req.pause ? TX_PAUSE : TX_SEND;
                    end
                end
                TX_PAUSE: begin
                    if (cnt == {div, 1'b0} - 1'b1) begin
                        cnt <= '0;
                        st  <= TX_SEND;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                TX_SEND: begin
                    if (cnt == {1'b0, div} - 1'b1) begin
                        cnt  <= '0;
                        sh   <= {1'b1, sh[FRAME_BITS-1:1]};
                        bitn <= bitn + 1'b1;
                        if (bitn == 4'(FRAME_BITS - 1)) begin
                            st   <= TX_IDLE;
                            done <= 1'b1;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: st <= TX_IDLE;
            endcase
        end
    end

    // R1
    stop_before_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> !$past(drv_lo));

endmodule

// File: rtl/mon_link_cmd.sv
module mon_link_cmd
    import mon_link_pkg::*;
#(
    parameter logic [BYTE_W-1:0] RD_OP = 8'h4A
) (
    input  logic              clk,
    input  logic              rst,
    input  rx_evt_t           evt,
    input  logic              tx_done,
    input  logic [BYTE_W-1:0] mem_data,
    output tx_req_t           req,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr
);

    cmd_state_e        st;
    logic [BYTE_W-1:0] hi, lo;

    always_comb begin
        req      = '0;
        mem_rd   = 1'b0;
        mem_addr = {hi, lo};
        if (evt.valid)      req = '{start: 1'b1, pause: 1'b0, data: evt.data};
        else if (evt.brk)   req = '{start: 1'b1, pause: 1'b1, data: '0};
        else if (st == CM_MEM) req = '{start: 1'b1, pause: 1'b0, data: mem_data};
        if (st == CM_ECHO && tx_done) mem_rd = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= CM_WAIT;
            hi <= '0;
            lo <= '0;
        end else if (evt.brk) begin
            st <= CM_WAIT;
        end else begin
            unique case (st)
                CM_WAIT:   if (evt.valid && evt.data == RD_OP) st <= CM_HI;
                CM_HI:     if (evt.valid) begin hi <= evt.data; st <= CM_LO; end
                CM_LO:     if (evt.valid) begin lo <= evt.data; st <= CM_ECHO; end
                CM_ECHO:   if (tx_done) st <= CM_MEM;
                CM_MEM:    st <= CM_RESULT;
                CM_RESULT: if (tx_done) st <= CM_WAIT;
                default:   st <= CM_WAIT;
            endcase
        end
    end

    // R4
    rd_single_chk: assert property (@(posedge clk) disable iff (rst)
        mem_rd |=> !mem_rd);

endmodule

// File: rtl/mon_link.sv
module mon_link
    import mon_link_pkg::*;
#(
    parameter int                DIV_W = 16,
    parameter logic [BYTE_W-1:0] RD_OP = 8'h4A
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              line_in,
    input  logic [DIV_W-1:0]  baud_div,
    output logic              line_pull_low,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [BYTE_W-1:0] mem_data
);

    rx_evt_t evt;
    tx_req_t req;
    logic    tx_busy, tx_done;

    mon_link_rx #(.DIV_W(DIV_W)) u_rx (
        .clk(clk), .rst(rst), .line_in(line_in), .tx_busy(tx_busy),
        .div(baud_div), .evt(evt)
    );

    mon_link_cmd #(.RD_OP(RD_OP)) u_cmd (
        .clk(clk), .rst(rst), .evt(evt), .tx_done(tx_done),
        .mem_data(mem_data), .req(req), .mem_rd(mem_rd), .mem_addr(mem_addr)
    );

    mon_link_tx #(.DIV_W(DIV_W)) u_tx (
        .clk(clk), .rst(rst), .div(baud_div), .req(req),
        .busy(tx_busy), .done(tx_done), .drv_lo(line_pull_low)
    );

    // R2
    echo_follows_chk: assert property (@(posedge clk) disable iff (rst)
        (evt.valid || evt.brk) |=> tx_busy);

    // R5
    read_while_idle_chk: assert property (@(posedge clk) disable iff (rst)
        mem_rd |-> !tx_busy);

    // R5
    result_start_chk: assert property (@(posedge clk) disable iff (rst)
        mem_rd |-> ##2 tx_busy);

endmodule

// File: tb/mon_link_test.sv
module mon_link_test;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host = 1'b1;
    logic [15:0] div = 16'd8;
    logic        pull, mem_rd;
    logic [15:0] mem_addr;
    logic [7:0]  mem_q = 8'h00;
    wire         line = host & ~pull;

    mon_link uut (
        .clk(clk), .rst(rst), .line_in(line), .baud_div(div),
        .line_pull_low(pull), .mem_rd(mem_rd), .mem_addr(mem_addr),
        .mem_data(mem_q)
    );

    always #(CLK_P/2) clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [7:0] memf(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    always @(posedge clk) if (mem_rd) mem_q <= memf(mem_addr);

    bit          exp_lo[int];
    string       exp_tag[int];
    logic [15:0] exp_rd[int];
    int          vecs = 0, bad = 0;
    bit          cmp_on = 0;
    int          N = 8;
    int          mstate = 0;
    logic [7:0]  mhi = 8'h00;
    int          last_t0 = 0;

    // every-cycle comparison against the behavioural expectation
    always @(negedge clk) begin
        if (cmp_on) begin
            bit e;
            string t;
            e = exp_lo.exists(cyc) ? exp_lo[cyc] : 1'b0;
            t = exp_tag.exists(cyc) ? exp_tag[cyc] : "R3/R9/R11 quiet line";
            vecs++;
            if (pull !== e) begin
                bad++;
                $display("FAIL %s cyc %0d: line_pull_low=%b expected %b", t, cyc, pull, e);
            end
            vecs++;
            if (exp_rd.exists(cyc)) begin
                if (mem_rd !== 1'b1 || mem_addr !== exp_rd[cyc]) begin
                    bad++;
                    $display("FAIL R4 cyc %0d: mem_rd=%b addr=%h expected 1 addr=%h",
                             cyc, mem_rd, mem_addr, exp_rd[cyc]);
                end
            end else if (mem_rd !== 1'b0) begin
                bad++;
                $display("FAIL R6/R8 cyc %0d: mem_rd=%b expected 0", cyc, mem_rd);
            end
        end
    end

    task automatic sched_frame(input int s, input logic [7:0] d, input string tag);
        for (int b = 0; b < 10; b++) begin
            bit lvl;
            lvl = (b == 0) ? 1'b0 : (b == 9) ? 1'b1 : d[b-1];
            for (int k = 0; k < N; k++) begin
                exp_lo[s + b*N + k]  = !lvl;
                exp_tag[s + b*N + k] = tag;
            end
        end
    endtask

    task automatic wait_until(input int t);
        while (cyc < t) @(negedge clk);
    endtask

    // host sends one frame; brk: ten low periods; bad_stop: low stop bit
    task automatic host_send(input logic [7:0] d, input bit brk, input bit bad_stop,
                             input string tag);
        int e0, t0, end_t;
        @(negedge clk);
        e0 = cyc + 1;
        t0 = e0 + N/2 + 9*N + 1;
        last_t0 = t0;
        end_t = e0 + 10*N;
        if (brk) begin
            sched_frame(t0 + 2*N, 8'h00, "R7 break answer");
            mstate = 0;
            end_t = t0 + 12*N;
        end else if (!bad_stop) begin
            sched_frame(t0, d, tag);
            end_t = t0 + 10*N;
            case (mstate)
                0: if (d == 8'h4A) mstate = 1;
                1: begin mhi = d; mstate = 2; end
                default: begin
                    exp_rd[t0 + 10*N] = {mhi, d};
                    sched_frame(t0 + 10*N + 2, memf({mhi, d}), "R5 read result");
                    end_t = t0 + 20*N + 2;
                    mstate = 0;
                end
            endcase
        end
        host = 1'b0;
        repeat (N) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            host = brk ? 1'b0 : d[i];
            repeat (N) @(negedge clk);
        end
        host = (brk || bad_stop) ? 1'b0 : 1'b1;
        repeat (N) @(negedge clk);
        host = 1'b1;
        wait_until(end_t + 3);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10 reset state
        vecs++;
        if (pull !== 1'b0 || mem_rd !== 1'b0) begin
            bad++;
            $display("FAIL R10 reset: pull=%b mem_rd=%b expected 0 0", pull, mem_rd);
        end
        rst = 1'b0;
        cmp_on = 1'b1;
        repeat (5) @(negedge clk);

        // R6 non-opcode byte, echo only
        host_send(8'h3C, 0, 0, "R1/R2/R6 echo");
        // R4 full read command
        host_send(8'h4A, 0, 0, "R2 opcode echo");
        host_send(8'h12, 0, 0, "R2 addr-hi echo");
        host_send(8'h34, 0, 0, "R2/R4 addr-lo echo");
        // R3 short low glitch rejected
        @(negedge clk);
        host = 1'b0;
        repeat (2) @(negedge clk);
        host = 1'b1;
        repeat (3*N) @(negedge clk);
        // R7 break
        host_send(8'h00, 1, 0, "R7");
        // R8 break aborts a partial command
        host_send(8'h4A, 0, 0, "R2 opcode echo");
        host_send(8'h00, 1, 0, "R7");
        host_send(8'h12, 0, 0, "R8 echo only after break");
        host_send(8'h34, 0, 0, "R8 echo only after break");
        // R11 low stop with nonzero data
        host_send(8'h81, 0, 1, "R11");
        // R9 host pulse during an echo
        fork
            host_send(8'h55, 0, 0, "R9 echo");
            begin
                repeat (N/2 + 9*N + 3*N + 4) @(negedge clk);
                host = 1'b0;
                repeat (N) @(negedge clk);
                host = 1'b1;
            end
        join
        // R1 new divisor, full read
        div = 16'd11;
        N = 11;
        repeat (4) @(negedge clk);
        host_send(8'h4A, 0, 0, "R1 divisor 11 echo");
        host_send(8'hA0, 0, 0, "R1 divisor 11 echo");
        host_send(8'h0F, 0, 0, "R1/R4 divisor 11 echo");
        host_send(8'h77, 0, 0, "R1/R6 divisor 11 echo");
        repeat (10) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
        $finish;
    end

endmodule